// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves like a small, byte-organised serial EEPROM. It holds 128 one-byte cells in an internal register array. A master on the two-wire bus can write one byte or a page of bytes, read from an address it names, or keep reading from wherever the internal pointer was left. The block samples SCL and SDA with the system clock through synchronisers and finds Start, repeated Start and Stop from the synchronised lines. It drives SDA only as an open-drain pull-down enable.

Written bytes first go into a page buffer of eight entries. They reach the array only when a Stop ends the write transfer. A timed programming cycle follows. Its length is the `PROG_CYCLES` parameter, counted in system clocks. During that cycle the device ignores its own address, so a master can poll it until it answers again. A write-protect input keeps the bus handshake the same but leaves the array unchanged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The slave acknowledges a control byte only when its top four bits are 1010 and the next three bits equal `csel_i`. Bit 0 is the direction, where 1 means read. On a mismatch it leaves SDA released through the acknowledge slot.
- R2: In a write, the byte after the control byte is the word address. Its low 7 bits set the internal pointer. The slave acknowledges the address byte and every data byte after it.
- R3: Each data byte goes to the page-buffer entry chosen by pointer bits [2:0]. Only those three bits then increment, so a ninth byte, or any byte past the page end, wraps to the start of the same 8-byte page and replaces the entry buffered there.
- R4: Buffered bytes are copied into the array only when a Stop ends the write. A Start or repeated Start that arrives first discards the buffer, and the array keeps its old contents.
- R5: For `PROG_CYCLES` system clocks after a commit, the slave does not acknowledge any control byte. After that cycle it acknowledges again.
- R6: In a read, the slave sends the byte at the pointer, MSB first, and increments the pointer after each byte. It sends another byte after each master ACK (SDA low in the ninth clock). After a master NACK it releases SDA and sends nothing more until the next Start.
- R7: A read with no address phase starts at the pointer, which is one past the last byte read or written. A random read is a write control byte, a word address, a repeated Start and a read control byte. During reads the pointer wraps from 127 to 0.
- R8: While `wp_i` is high, write transfers are acknowledged in full, but the Stop leaves the array unchanged and starts no programming cycle.
- R9: After reset `sda_oe_o` is 0. The slave changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| csel_i | input | 3 | Chip-select bits compared with control byte bits [3:1] |
| wp_i | input | 1 | Write protect; high blocks the commit to the array |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The hardest case to reach from the ports is a transfer that ends without a Stop. The bench sends a write control byte, an address and a data byte, then issues a repeated Start and a read control byte. The byte read back must come from the advanced pointer, and a later random read of the abandoned address must return its old value. A second hard case is the busy window. Right after the Stop of a write, a control byte must get no acknowledge, and after the programming delay the reads that follow must be acknowledged again. Page wrap is reached by starting a four-byte write two entries before the end of a page.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDAT,
        ST_ACK,
        ST_RD,
        ST_RACK
    } ee_state_e;

endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], d_i[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end

            assign q_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ee_bus_events.sv
module ee_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign rise_o  = !prev_q.scl &&  scl_s_i;
    assign fall_o  =  prev_q.scl && !scl_s_i;
    assign start_o =  prev_q.scl &&  scl_s_i &&  prev_q.sda && !sda_s_i;
    assign stop_o  =  prev_q.scl &&  scl_s_i && !prev_q.sda &&  sda_s_i;

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     discard_i,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     busy_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic [7:0]        mem_q  [DEPTH];
    logic [7:0]        pbuf_q [PAGE];
    logic [PAGE-1:0]   pval_d, pval_q;
    logic [TMR_W-1:0]  tmr_d, tmr_q;
    logic              commit_go;

    assign busy_o    = (tmr_q != '0);
    assign commit_go = commit_i && (pval_q != '0) && !busy_o;
    assign rd_data_o = mem_q[rd_addr_i];

    always_comb begin
        pval_d = pval_q;
        tmr_d  = tmr_q;
        if (busy_o) tmr_d = tmr_q - 1'b1;
        if (commit_go) begin
            tmr_d  = TMR_W'(PROG_CYCLES);
            pval_d = '0;
        end else if (discard_i || commit_i) begin
            pval_d = '0;
        end else if (buf_we_i) begin
            pval_d[buf_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pval_q <= '0;
            tmr_q  <= '0;
        end else begin
            pval_q <= pval_d;
            tmr_q  <= tmr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we_i) pbuf_q[buf_idx_i] <= buf_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_go) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pval_q[i]) mem_q[{page_i, PAGE_W'(i)}] <= pbuf_q[i];
            end
        end
    end

    AST_COMMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && pval_q != '0) |-> !busy_o); // R5

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q > TMR_W'(1)) |=> busy_o); // R5

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] csel_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    import ee_pkg::*;

    localparam int HI_W = ADDR_W - PAGE_W;

    typedef struct packed {
        ee_state_e          st;
        ee_state_e          nxt;
        logic [3:0]         bitcnt;
        logic [7:0]         sh;
        logic               oe;
        logic [ADDR_W-1:0]  ptr;
        logic               mack;
    } fsm_t;

    fsm_t q, n;

    logic [1:0]        sync_s;
    logic              scl_s, sda_s;
    logic              ev_rise, ev_fall, ev_start, ev_stop;
    logic              buf_we, discard, commit, busy;
    logic [7:0]        rd_data;
    logic              ctrl_hit;

    ee_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (sync_s)
    );
    assign scl_s = sync_s[1];
    assign sda_s = sync_s[0];

    ee_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s_i (scl_s),
        .sda_s_i (sda_s),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall),
        .start_o (ev_start),
        .stop_o  (ev_stop)
    );

    ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_we_i   (buf_we),
        .buf_idx_i  (q.ptr[PAGE_W-1:0]),
        .buf_data_i (q.sh),
        .discard_i  (discard),
        .commit_i   (commit),
        .page_i     (q.ptr[ADDR_W-1:PAGE_W]),
        .rd_addr_i  (q.ptr),
        .rd_data_o  (rd_data),
        .busy_o     (busy)
    );

    assign ctrl_hit = (q.sh[7:4] == DEV_CODE) && (q.sh[3:1] == csel_i);
    assign sda_oe_o = q.oe;

    always_comb begin
        n       = q;
        buf_we  = 1'b0;
        discard = 1'b0;
        commit  = 1'b0;

        if (ev_start) begin
            n.st     = ST_CTRL;
            n.bitcnt = '0;
            n.oe     = 1'b0;
            discard  = 1'b1;
        end else if (ev_stop) begin
            n.st    = ST_IDLE;
            n.oe    = 1'b0;
            commit  = !wp_i;
            discard = wp_i;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_CTRL, ST_ADDR, ST_WDAT: begin
                    if (ev_rise) begin
                        n.sh     = {q.sh[6:0], sda_s};
                        n.bitcnt = q.bitcnt + 1'b1;
                    end else if (ev_fall && q.bitcnt == 4'd8) begin
                        n.st = ST_ACK;
                        n.oe = 1'b1;
                        if (q.st == ST_CTRL) begin
                            n.nxt = q.sh[0] ? ST_RD : ST_ADDR;
                            if (!ctrl_hit || busy) begin
                                n.st = ST_IDLE;
                                n.oe = 1'b0;
                            end
                        end else if (q.st == ST_ADDR) begin
                            n.ptr = q.sh[ADDR_W-1:0];
                            n.nxt = ST_WDAT;
                        end else begin
                            buf_we = 1'b1;
                            n.ptr  = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + 1'b1};
                            n.nxt  = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        n.oe     = 1'b0;
                        n.bitcnt = '0;
                        if (q.nxt == ST_RD) begin
                            n.st  = ST_RD;
                            n.sh  = rd_data;
                            n.oe  = !rd_data[7];
                            n.ptr = q.ptr + 1'b1;
                        end else begin
                            n.st = q.nxt;
                        end
                    end
                end
                ST_RD: begin
                    if (ev_rise) begin
                        n.bitcnt = q.bitcnt + 1'b1;
                    end else if (ev_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            n.oe = 1'b0;
                            n.st = ST_RACK;
                        end else begin
                            n.sh = {q.sh[6:0], 1'b0};
                            n.oe = !q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        n.mack = !sda_s;
                    end else if (ev_fall) begin
                        if (q.mack) begin
                            n.st     = ST_RD;
                            n.bitcnt = '0;
                            n.sh     = rd_data;
                            n.oe     = !rd_data[7];
                            n.ptr    = q.ptr + 1'b1;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: n.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, bitcnt: '0, sh: '0,
                   oe: 1'b0, ptr: '0, mack: 1'b0};
        end else begin
            q <= n;
        end
    end

    AST_CTRL_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CTRL && ev_fall && !ev_start && !ev_stop && q.bitcnt == 4'd8 && !ctrl_hit) |=> !sda_oe_o); // R1

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CTRL && ev_fall && !ev_start && !ev_stop && q.bitcnt == 4'd8 && busy) |=> !sda_oe_o); // R5

    AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> q.ptr[ADDR_W-1:PAGE_W] == $past(q.ptr[ADDR_W-1:PAGE_W])); // R3

    AST_RELEASE_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RACK && ev_fall && !ev_start && !ev_stop && !q.mack) |=> !sda_oe_o); // R6

    AST_WP_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && wp_i && !busy) |=> !busy); // R8

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R9

endmodule

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 10;
    localparam int PROG       = 400;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] csel = 3'b101;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int hi_changes = 0;

    logic [7:0] ref_mem [128];
    logic [6:0] ref_ptr = '0;

    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];
    event       got_ev;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_slave #(.PROG_CYCLES(PROG)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .csel_i   (csel),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected and actual bytes and compares them
    initial begin
        forever begin
            @(got_ev);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                automatic logic [7:0] a = act_q.pop_front();
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(a == e, t, a, e);
            end
        end
    end

    // R9: the slave output must not move while the bench holds SCL high
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && scl && sda_oe != oe_prev) hi_changes++;
        oe_prev <= sda_oe;
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp();
        scl = 1'b1;   hp();
        sda_m = 1'b0; hp();
        scl = 1'b0;   hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp();
        scl = 1'b1;   hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp();
            scl = 1'b1;   hp();
            scl = 1'b0;
        end
        sda_m = 1'b1; hp();
        ack = !sda_line;
        scl = 1'b1; hp();
        scl = 1'b0;
    endtask

    task automatic rbyte(input bit give_ack, input string tag);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            scl = 1'b1;
            b[i] = sda_line;
            hp();
            scl = 1'b0;
        end
        sda_m = !give_ack; hp();
        scl = 1'b1; hp();
        scl = 1'b0;
        sda_m = 1'b1;
        exp_q.push_back(ref_mem[ref_ptr]);
        tag_q.push_back(tag);
        act_q.push_back(b);
        ref_ptr = ref_ptr + 1'b1;
        -> got_ev;
    endtask

    function automatic logic [7:0] ctrl(input bit rd);
        return {4'b1010, csel, rd};
    endfunction

    // write transfer: address then bytes, Stop; updates model unless protected
    task automatic wr_seq(input logic [6:0] addr, input logic [7:0] d [$], input string tag);
        bit ack;
        logic [6:0] p;
        bus_start();
        wbyte(ctrl(0), ack); check(ack, {tag, " ctrl ack"}, ack, 1);
        wbyte({1'b0, addr}, ack); check(ack, {tag, " addr ack"}, ack, 1);
        p = addr;
        foreach (d[k]) begin
            wbyte(d[k], ack); check(ack, {tag, " data ack"}, ack, 1);
            if (!wp) ref_mem[p] = d[k];
            p = {p[6:3], p[2:0] + 3'd1};
        end
        ref_ptr = p;
        bus_stop();
    endtask

    task automatic rd_seq(input bit random, input logic [6:0] addr, input int cnt, input string tag);
        bit ack;
        bus_start();
        if (random) begin
            wbyte(ctrl(0), ack); check(ack, {tag, " ctrl ack"}, ack, 1);
            wbyte({1'b0, addr}, ack); check(ack, {tag, " addr ack"}, ack, 1);
            ref_ptr = addr;
            bus_start();
        end
        wbyte(ctrl(1), ack); check(ack, {tag, " rd ctrl ack"}, ack, 1);
        for (int k = 0; k < cnt; k++) rbyte(k != cnt - 1, tag);
        check(sda_oe == 1'b0, {tag, " released after NACK"}, sda_oe, 0);
        bus_stop();
    endtask

    task automatic settle();
        repeat (PROG + 40) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R9 reset state", sda_oe, 0);

        // R1: wrong chip select is not acknowledged
        bus_start();
        wbyte({4'b1010, 3'b010, 1'b0}, ack);
        check(!ack, "R1 chip-select mismatch nack", ack, 0);
        bus_stop();
        bus_start();
        wbyte({4'b1110, csel, 1'b0}, ack);
        check(!ack, "R1 device-code mismatch nack", ack, 0);
        bus_stop();

        // R2 byte write, then R5 busy poll
        wr_seq(7'h05, '{8'hA5}, "R2 byte write");
        bus_start();
        wbyte(ctrl(0), ack);
        check(!ack, "R5 busy nack after commit", ack, 0);
        bus_stop();
        settle();

        // R6 random read followed by sequential bytes; R5 ack after the window
        rd_seq(1, 7'h05, 3, "R6 sequential read");

        // R3 page write crossing the page end wraps within the page
        wr_seq(7'h0E, '{8'h11, 8'h22, 8'h33, 8'h44}, "R3 page write");
        settle();
        wr_seq(7'h10, '{8'h5C}, "R2 byte write 0x10");
        settle();
        rd_seq(1, 7'h08, 8, "R3 page wrap readback");

        // R7 current-address read continues at 0x10
        rd_seq(0, 7'h00, 1, "R7 current-address read");

        // R7 pointer wrap 127 -> 0
        wr_seq(7'h7F, '{8'hEE}, "R2 byte write 0x7F");
        settle();
        wr_seq(7'h00, '{8'h3D}, "R2 byte write 0x00");
        settle();
        rd_seq(1, 7'h7F, 2, "R7 pointer wrap");

        // R8 write protect: acked, not stored, no busy window
        wp = 1'b1;
        wr_seq(7'h20, '{8'h99, 8'h98}, "R8 protected write");
        wp = 1'b0;
        rd_seq(1, 7'h20, 2, "R8 protected readback");

        // R4 write abandoned by a repeated Start is discarded
        bus_start();
        wbyte(ctrl(0), ack); check(ack, "R4 ctrl ack", ack, 1);
        wbyte(8'h30, ack);   check(ack, "R4 addr ack", ack, 1);
        wbyte(8'h77, ack);   check(ack, "R4 data ack", ack, 1);
        ref_ptr = 7'h31;
        bus_start();
        wbyte(ctrl(1), ack); check(ack, "R4 no busy after abort", ack, 1);
        rbyte(1'b0, "R4 read after abort");
        bus_stop();
        rd_seq(1, 7'h30, 1, "R4 abandoned byte not stored");

        repeat (20) @(negedge clk);
        -> got_ev;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        check(hi_changes == 0, "R9 no output change while SCL high", hi_changes, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule